// File: doc/BRIEF.md
# Radiation-Tolerant Delay-Line Tuning Controller

This block is the digital loop of an all-digital delay-locked loop. It reads early/late votes from a coarse and a fine phase detector each clock, and steers two delay-line settings. Tuning runs in two stages. The coarse stage first walks the coarse setting until the detector starts to oscillate. The coarse setting is then frozen, and the fine stage trims the delay and reports lock.

Both settings are held as thermometer codes. Each accumulator register and each piece of control state exists in three copies. Every copy is bubble-corrected with a three-bit majority window, and the three corrected copies are then voted bit by bit. The next state is computed from the voted value and written back into all three copies. A single upset in one copy is therefore invisible at the outputs, and it is overwritten at the next edge.

Top module: `dll_tune_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in the coarse stage with coarseCode = 8'h0F (4 ones), fineCode = 16'h00FF (8 ones) and locked low.
- R2: A decision is qualified only when exactly one of the stage's up/down inputs is high. Up adds a one just above the run of ones (the code shifts left, filling bit 0), and down removes the top one. Both high or both low leaves the codes unchanged.
- R3: Both codes saturate. Up at all-ones and down at all-zeros leave the code unchanged.
- R4: During the coarse stage, fineUp and fineDn have no effect and fineCode stays at its midpoint.
- R5: The coarse stage ends on the second consecutive qualified coarse decision that reverses direction. Idle cycles between decisions do not break the run. That decision still moves coarseCode. From the next cycle on, coarseCode is frozen, coarseUp and coarseDn are ignored, and the block never returns to the coarse stage before reset.
- R6: coarseCode and fineCode are always valid thermometer codes, with the ones contiguous from bit 0.
- R7: Flipping one bit of one copy of either accumulator, or flipping the stage bit of one control copy, changes no output in that cycle or later. This holds in either stage. A second upset in another copy after a clock edge is also tolerated.
- R8: locked rises on the eighth consecutive qualified fine decision that reverses the previous fine decision. A decision in the same direction restarts the count. Once set, locked stays high until R9 applies.
- R9: At a clock edge where fineCode is all-ones or all-zeros, locked clears and the reversal count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarseUp | input | 1 | Coarse detector: add delay |
| coarseDn | input | 1 | Coarse detector: remove delay |
| fineUp | input | 1 | Fine detector: add delay |
| fineDn | input | 1 | Fine detector: remove delay |
| coarseCode | output | 8 | Voted, corrected coarse thermometer setting |
| fineCode | output | 16 | Voted, corrected fine thermometer setting |
| locked | output | 1 | Fine loop is dithering by one step |

## Verification
Stage handover and coarse stepping happen on the same edge. The reversing coarse decision that ends the coarse stage also moves the coarse code by one step. The bench sends up, up, up, down, an idle cycle, then up, and expects three things: the coarse code one step higher, the fine code still at its midpoint, and later coarse requests ignored. Lock entry and lock clearing can also meet. The bench reaches lock while dithering and then drives the fine code to its upper end. It expects locked to stay high on the edge where the code arrives at the end and to fall on the next edge.

// File: rtl/dll_tune_pkg.sv
package dll_tune_pkg;
  localparam int COPIES = 3;

  // strobes from the control stage to the accumulator datapath
  typedef struct packed {
    logic coarseInc;
    logic coarseDec;
    logic fineInc;
    logic fineDec;
    logic fineLoad;
  } tuneStb_t;
endpackage

// File: rtl/dll_tune_tacc.sv
module dll_tune_tacc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] thermD,
  output logic [W-1:0] thermFix
);
  localparam logic [W-1:0] MID = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};

  logic [W-1:0] thermQ;
  logic [W+1:0] ext;

  always_ff @(posedge clk) begin
    if (rst) thermQ <= MID;
    else     thermQ <= thermD;
  end

  // out-of-range neighbours: 1 below bit 0, 0 above the top bit
  assign ext = {1'b0, thermQ, 1'b1};

  for (genvar i = 0; i < W; i++) begin : gFix
    assign thermFix[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
  end
endmodule

// File: rtl/dll_tune_dp.sv
module dll_tune_dp
  import dll_tune_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  tuneStb_t      stb,
  output logic [CW-1:0] coarseCode,
  output logic [FW-1:0] fineCode
);
  localparam logic [FW-1:0] FMID = {{(FW - FW/2){1'b0}}, {(FW/2){1'b1}}};

  logic [CW-1:0] cFix [COPIES];
  logic [FW-1:0] fFix [COPIES];
  logic [CW-1:0] cNext;
  logic [FW-1:0] fNext;

  for (genvar k = 0; k < COPIES; k++) begin : gCo
    dll_tune_tacc #(.W(CW)) u_acc (.clk(clk), .rst(rst), .thermD(cNext), .thermFix(cFix[k]));
  end
  for (genvar k = 0; k < COPIES; k++) begin : gFi
    dll_tune_tacc #(.W(FW)) u_acc (.clk(clk), .rst(rst), .thermD(fNext), .thermFix(fFix[k]));
  end

  assign coarseCode = (cFix[0] & cFix[1]) | (cFix[0] & cFix[2]) | (cFix[1] & cFix[2]);
  assign fineCode   = (fFix[0] & fFix[1]) | (fFix[0] & fFix[2]) | (fFix[1] & fFix[2]);

  always_comb begin
    cNext = coarseCode;
    if (stb.coarseInc && !coarseCode[CW-1])  cNext = {coarseCode[CW-2:0], 1'b1};
    else if (stb.coarseDec && coarseCode[0]) cNext = {1'b0, coarseCode[CW-1:1]};
  end

  always_comb begin
    fNext = fineCode;
    if (stb.fineLoad)                       fNext = FMID;
    else if (stb.fineInc && !fineCode[FW-1]) fNext = {fineCode[FW-2:0], 1'b1};
    else if (stb.fineDec && fineCode[0])    fNext = {1'b0, fineCode[FW-1:1]};
  end
endmodule

// File: rtl/dll_tune_ctl.sv
module dll_tune_ctl
  import dll_tune_pkg::*;
#(
  parameter int LOCK_RUN = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     coarseUp,
  input  logic     coarseDn,
  input  logic     fineUp,
  input  logic     fineDn,
  input  logic     fineAtEnd,
  output tuneStb_t stb,
  output logic     fineStage,
  output logic     locked
);
  localparam int LCW = $clog2(LOCK_RUN + 1);

  typedef struct packed {
    logic           hasLast;
    logic           lastUp;
    logic [1:0]     revCnt;
    logic [LCW-1:0] lockCnt;
    logic           locked;
  } ctlSt_t;

  ctlSt_t stCp [COPIES];
  logic   stgCp [COPIES];
  ctlSt_t stV, stN;
  logic   stgV, stgN;
  logic   qual, dirUp, rev;

  for (genvar k = 0; k < COPIES; k++) begin : gCp
    ctlSt_t stQ;
    logic   fineStgQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        stQ      <= '0;
        fineStgQ <= 1'b0;
      end else begin
        stQ      <= stN;
        fineStgQ <= stgN;
      end
    end
    assign stCp[k]  = stQ;
    assign stgCp[k] = fineStgQ;
  end

  assign stV  = (stCp[0] & stCp[1]) | (stCp[0] & stCp[2]) | (stCp[1] & stCp[2]);
  assign stgV = (stgCp[0] & stgCp[1]) | (stgCp[0] & stgCp[2]) | (stgCp[1] & stgCp[2]);

  assign qual  = stgV ? (fineUp ^ fineDn) : (coarseUp ^ coarseDn);
  assign dirUp = stgV ? fineUp : coarseUp;
  assign rev   = qual && stV.hasLast && (dirUp != stV.lastUp);

  always_comb begin
    stN  = stV;
    stgN = stgV;
    stb  = '0;
    if (qual) begin
      stN.hasLast = 1'b1;
      stN.lastUp  = dirUp;
    end
    if (!stgV) begin
      stb.coarseInc = qual && dirUp;
      stb.coarseDec = qual && !dirUp;
      if (qual) stN.revCnt = rev ? stV.revCnt + 2'd1 : 2'd0;
      if (rev && stV.revCnt == 2'd1) begin
        stgN         = 1'b1;
        stN.hasLast  = 1'b0;
        stN.revCnt   = 2'd0;
        stb.fineLoad = 1'b1;
      end
    end else begin
      stb.fineInc = qual && dirUp;
      stb.fineDec = qual && !dirUp;
      if (qual) begin
        if (!rev) stN.lockCnt = '0;
        else if (stV.lockCnt != LCW'(LOCK_RUN)) stN.lockCnt = stV.lockCnt + LCW'(1);
        if (rev && stV.lockCnt == LCW'(LOCK_RUN - 1)) stN.locked = 1'b1;
      end
      if (fineAtEnd) begin
        stN.locked  = 1'b0;
        stN.lockCnt = '0;
      end
    end
  end

  assign fineStage = stgV;
  assign locked    = stV.locked;
endmodule

// File: rtl/dll_tune_ctrl.sv
module dll_tune_ctrl
  import dll_tune_pkg::*;
#(
  parameter int CW       = 8,
  parameter int FW       = 16,
  parameter int LOCK_RUN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coarseUp,
  input  logic          coarseDn,
  input  logic          fineUp,
  input  logic          fineDn,
  output logic [CW-1:0] coarseCode,
  output logic [FW-1:0] fineCode,
  output logic          locked
);
  tuneStb_t stb;
  logic     fineStage;
  logic     fineAtEnd;

  assign fineAtEnd = (&fineCode) | ~(|fineCode);

  dll_tune_ctl #(.LOCK_RUN(LOCK_RUN)) u_ctl (
    .clk(clk), .rst(rst),
    .coarseUp(coarseUp), .coarseDn(coarseDn), .fineUp(fineUp), .fineDn(fineDn),
    .fineAtEnd(fineAtEnd), .stb(stb), .fineStage(fineStage), .locked(locked)
  );

  dll_tune_dp #(.CW(CW), .FW(FW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .coarseCode(coarseCode), .fineCode(fineCode)
  );
endmodule

// File: rtl/dll_tune_chk.sv
module dll_tune_chk #(
  parameter int CW = 8,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          fineStage,
  input logic          locked,
  input logic [CW-1:0] coarseCode,
  input logic [FW-1:0] fineCode
);
  localparam logic [FW-1:0] FMID = {{(FW - FW/2){1'b0}}, {(FW/2){1'b1}}};

  AST_ONE_STEP_COARSE: assert property (@(posedge clk) disable iff (rst)
    $countones(coarseCode ^ $past(coarseCode)) <= 1); // R2
  AST_ONE_STEP_FINE: assert property (@(posedge clk) disable iff (rst)
    $countones(fineCode ^ $past(fineCode)) <= 1); // R2
  AST_FINE_PARKED: assert property (@(posedge clk) disable iff (rst)
    !fineStage |-> fineCode == FMID); // R4
  AST_COARSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(fineStage) |-> $stable(coarseCode)); // R5
  AST_STAGE_ONEWAY: assert property (@(posedge clk) disable iff (rst)
    $past(fineStage) |-> fineStage); // R5
  AST_THERM_COARSE: assert property (@(posedge clk) disable iff (rst)
    (coarseCode & (coarseCode + 1'b1)) == '0); // R6
  AST_THERM_FINE: assert property (@(posedge clk) disable iff (rst)
    (fineCode & (fineCode + 1'b1)) == '0); // R6
  AST_LOCK_IN_FINE: assert property (@(posedge clk) disable iff (rst)
    locked |-> fineStage); // R8
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (locked && ((&fineCode) || !(|fineCode))) |=> !locked); // R9
endmodule

bind dll_tune_ctrl dll_tune_chk #(.CW(CW), .FW(FW)) chk_i (
  .clk(clk), .rst(rst), .fineStage(fineStage), .locked(locked),
  .coarseCode(coarseCode), .fineCode(fineCode)
);

// File: tb/dll_tune_ctrl_tb_top.sv
module dll_tune_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int FW = 16;
  localparam int LR = 8;

  typedef struct {
    logic [CW-1:0] c;
    logic [FW-1:0] f;
    logic          l;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coarseUp = 1'b0, coarseDn = 1'b0, fineUp = 1'b0, fineDn = 1'b0;
  logic [CW-1:0] coarseCode;
  logic [FW-1:0] fineCode;
  logic locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  expItem_t expQ[$];

  // reference model state
  int mc = CW/2, mf = FW/2, mRev = 0, mLock = 0;
  bit mStg = 0, mHas = 0, mLastUp = 0, mLocked = 0;

  logic [CW-1:0] sc;
  logic [FW-1:0] sf;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_tune_ctrl dut_i (
    .clk(clk), .rst(rst), .coarseUp(coarseUp), .coarseDn(coarseDn),
    .fineUp(fineUp), .fineDn(fineDn),
    .coarseCode(coarseCode), .fineCode(fineCode), .locked(locked)
  );

  function automatic logic [31:0] therm(input int n);
    return (32'd1 << n) - 32'd1;
  endfunction

  function automatic expItem_t curExp(input string tag);
    expItem_t e;
    e.c = therm(mc)[CW-1:0];
    e.f = therm(mf)[FW-1:0];
    e.l = mLocked;
    e.tag = tag;
    return e;
  endfunction

  task automatic model(input bit cu, input bit cd, input bit fu, input bit fd);
    bit q, up, rv, endNow;
    q      = mStg ? (fu ^ fd) : (cu ^ cd);
    up     = mStg ? fu : cu;
    rv     = q && mHas && (up != mLastUp);
    endNow = (mf == FW) || (mf == 0);
    if (!mStg) begin
      if (q) begin
        if (up && mc < CW) mc++;
        if (!up && mc > 0) mc--;
        if (rv && mRev == 1) begin
          mStg = 1; mHas = 0; mRev = 0;
        end else begin
          mRev = rv ? mRev + 1 : 0; mHas = 1; mLastUp = up;
        end
      end
    end else begin
      if (q) begin
        if (up && mf < FW) mf++;
        if (!up && mf > 0) mf--;
        mHas = 1; mLastUp = up;
        if (rv) begin
          if (mLock < LR) mLock++;
          if (mLock == LR) mLocked = 1;
        end else mLock = 0;
      end
      if (endNow) begin mLocked = 0; mLock = 0; end
    end
  endtask

  task automatic compare(input expItem_t e);
    checks++;
    if (coarseCode !== e.c || fineCode !== e.f || locked !== e.l) begin
      errors++;
      $display("FAIL %s: got coarse=%h fine=%h locked=%b, expected coarse=%h fine=%h locked=%b",
               e.tag, coarseCode, fineCode, locked, e.c, e.f, e.l);
    end
  endtask

  // driver: apply one decision and queue the expected result
  task automatic step(input bit cu, input bit cd, input bit fu, input bit fd, input string tag);
    @(negedge clk);
    coarseUp = cu; coarseDn = cd; fineUp = fu; fineDn = fd;
    model(cu, cd, fu, fd);
    expQ.push_back(curExp(tag));
  endtask

  // single-copy upset during an idle cycle
  task automatic upset(input int which, input string tag);
    expItem_t e;
    @(negedge clk);
    coarseUp = 0; coarseDn = 0; fineUp = 0; fineDn = 0;
    model(0, 0, 0, 0);
    e = curExp(tag);
    expQ.push_back(e);
    sc = dut_i.u_dp.gCo[1].u_acc.thermQ;
    sf = dut_i.u_dp.gFi[2].u_acc.thermQ;
    case (which)
      0: force dut_i.u_ctl.gCp[1].fineStgQ = 1'b1;
      1: force dut_i.u_dp.gCo[1].u_acc.thermQ = sc ^ 8'h20;
      2: force dut_i.u_ctl.gCp[0].fineStgQ = 1'b0;
      3: force dut_i.u_dp.gFi[2].u_acc.thermQ = sf ^ 16'h0004;
      default: ;
    endcase
    #1;
    compare(e);
    case (which)
      0: release dut_i.u_ctl.gCp[1].fineStgQ;
      1: release dut_i.u_dp.gCo[1].u_acc.thermQ;
      2: release dut_i.u_ctl.gCp[0].fineStgQ;
      3: release dut_i.u_dp.gFi[2].u_acc.thermQ;
      default: ;
    endcase
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare one item after each clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step(0, 0, 0, 0, "R1 reset state");
    step(1, 1, 0, 0, "R2 both coarse inputs");
    step(0, 0, 0, 0, "R2 no coarse input");
    step(0, 0, 1, 0, "R4 fine up in coarse stage");
    step(0, 0, 0, 1, "R4 fine down in coarse stage");
    upset(0, "R7 stage copy flip, coarse stage");
    upset(1, "R7 coarse accumulator copy flip");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R3 coarse up to top");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, "R3 coarse down to bottom");
    step(1, 0, 0, 0, "R5 first reversal");
    step(1, 0, 0, 0, "R5 run broken");
    step(1, 0, 0, 0, "R2 coarse up");
    step(0, 1, 0, 0, "R5 reversal one");
    step(0, 0, 0, 0, "R5 idle keeps run");
    step(1, 0, 0, 0, "R5 reversal two, handover");
    step(1, 0, 0, 0, "R5 coarse ignored in fine stage");
    step(0, 1, 0, 0, "R5 coarse ignored in fine stage");
    step(0, 0, 1, 1, "R2 both fine inputs");
    step(0, 0, 1, 0, "R2 fine up");
    for (int i = 0; i < 5; i++) step(0, 0, i % 2 == 1, i % 2 == 0, "R8 short dither");
    step(0, 0, 0, 1, "R8 same direction restarts");
    for (int i = 0; i < LR; i++) step(0, 0, i % 2 == 0, i % 2 == 1, "R8 dither to lock");
    upset(2, "R7 stage copy flip, fine stage");
    upset(3, "R7 fine accumulator copy flip");
    upset(1, "R7 coarse copy flip while frozen");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, "R9 fine up to top");
    step(0, 0, 0, 0, "R9 lock cleared at end");
    step(0, 0, 1, 0, "R3 fine saturates high");
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, "R3 fine down to bottom");
    step(0, 0, 0, 0, "R6 idle at bottom");
    repeat (3) @(posedge clk);
    #2;
    finishRun();
  end
endmodule